// File: doc/BRIEF.md
# Yield Qualifier and Deschedule Unit

This unit handles a yield request from the running thread. The request carries a signed descriptor. The value of the descriptor decides what happens to the thread: it is freed, it stays eligible but hands the processor to other threads, it only polls the qualifier inputs, or it blocks until chosen external qualifier bits become active. The unit checks each request against a qualifier mask, against two control bits that turn scheduler entry into a trap, and against the status of the other thread contexts on the same virtual processor. It then reports one outcome through a registered response, or raises a thread exception with a cause code. The scheduling policy itself lies outside this block.

The control flow is a two-state machine. ST_IDLE accepts requests. On a request with a valid positive descriptor, the transition "block" moves it to ST_WAIT. Every other request completes in ST_IDLE through the transition "complete". In ST_WAIT the unit tests the captured descriptor against the masked qualifier inputs on every cycle. The transition "release" takes it back to ST_IDLE on the first cycle with a match. With no match, the transition "hold" keeps it in ST_WAIT. A completion with a non-zero result index writes the masked qualifier inputs back.

Top module: `yield_qual_unit`

## Requirements
- R1: After reset the unit is in ST_IDLE, and blocked, resume, rsp_valid and wb_en are all 0.
- R2: A zero descriptor frees the context when a peer is eligible. A peer is eligible when it is bound to this processor, is not self_ctx, is allocatable, is not halted and is active. The response comes in the cycle after the request edge, with rsp_valid, rsp_dealloc and rsp_resched set.
- R3: A zero descriptor with no eligible peer raises rsp_exc with rsp_cause 0. It gives no dealloc, no reschedule and no writeback.
- R4: Descriptor all-ones (-1) gives rsp_resched without dealloc.
- R5: Descriptor -2 (all ones except bit 0) only returns the qualifier result. No reschedule occurs, and no trap occurs even when both trap bits are set.
- R6: A positive descriptor with any bit set that is clear in qual_mask raises rsp_exc with rsp_cause 2.
- R7: When sched_trap_en and thread_debug are both 1, a request that would enter the scheduler raises rsp_exc with rsp_cause 4 and has no other effect. Such requests are a zero descriptor with an eligible peer, -1, or a valid positive descriptor.
- R8: A valid positive descriptor without a trap pulses rsp_resched and asserts blocked from the cycle after the request. Blocked stays high while no match is seen.
- R9: While blocked, the first clock edge at which (descriptor & qual_mask & qual_in) is non-zero makes blocked fall in the next cycle. In that same cycle resume pulses and the writeback is issued.
- R10: wb_data is {0, qual_in & qual_mask}, sampled at the completing edge. wb_en is set only when the result index is non-zero and no exception is raised.
- R11: A negative descriptor other than -1 or -2 pulses rsp_rsvd only, with no exception cause, no writeback and no blocking.
- R12: Requests presented while blocked are ignored: they produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Yield request strobe |
| req_desc | input | QW+1 | Signed yield descriptor |
| req_rs | input | 5 | Result register index, 0 means no writeback |
| qual_in | input | QW | Live qualifier inputs |
| qual_mask | input | QW | Qualifier enable mask |
| sched_trap_en | input | 1 | Trap-on-scheduler enable, processor side |
| thread_debug | input | 1 | Trap-on-scheduler enable, thread side |
| ctx_bound | input | NCTX | Context bound to this processor |
| ctx_alloc | input | NCTX | Context dynamically allocatable |
| ctx_halted | input | NCTX | Context halted |
| ctx_active | input | NCTX | Context active |
| self_ctx | input | CW | Index of the issuing context |
| blocked | output | 1 | Issuing thread is waiting on qualifiers |
| resume | output | 1 | One-cycle pulse when a wait ends |
| rsp_valid | output | 1 | Response to an accepted request |
| rsp_dealloc | output | 1 | Free the issuing context |
| rsp_resched | output | 1 | Invoke the scheduler |
| rsp_exc | output | 1 | Thread exception |
| rsp_cause | output | 3 | Exception cause: 0, 2 or 4 |
| rsp_rsvd | output | 1 | Reserved-instruction exception |
| wb_en | output | 1 | Result writeback strobe |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | QW+1 | Masked qualifier result |

## Verification
All response fields, resume and wb_* are registered. They are due in the cycle after the clock edge that samples the request or the match, and each lasts one cycle. Blocked follows the state register, so it rises in that same cycle after the request and falls in the cycle where resume pulses. The bench drives stimulus on the falling edge and reads every result on the next falling edge, exactly one rising edge later. While waiting it holds non-matching inputs, then checks after each single edge that blocked stays high and that a stray request draws no response.

// File: rtl/yq_pkg.sv
package yq_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } yq_state_t;

    typedef enum logic [2:0] {
        DK_FREE,
        DK_RESCHED,
        DK_POLL,
        DK_WAIT,
        DK_RSVD
    } yq_kind_t;

    localparam logic [2:0] CAUSE_UNDERFLOW = 3'd0;
    localparam logic [2:0] CAUSE_BADQUAL   = 3'd2;
    localparam logic [2:0] CAUSE_SCHED     = 3'd4;

endpackage

// File: rtl/yq_decode.sv
module yq_decode
    import yq_pkg::*;
#(
    parameter int QW = 31
) (
    input  logic [QW:0]   desc,
    input  logic [QW-1:0] mask,
    output yq_kind_t      kind,
    output logic          bad_qual
);
    localparam logic [QW:0] ALL_ONES  = '1;
    localparam logic [QW:0] MINUS_TWO = {{QW{1'b1}}, 1'b0};

    always_comb begin
        if (desc == '0) begin
            kind = DK_FREE;
        end else if (desc == ALL_ONES) begin
            kind = DK_RESCHED;
        end else if (desc == MINUS_TWO) begin
            kind = DK_POLL;
        end else if (!desc[QW]) begin
            kind = DK_WAIT;
        end else begin
            kind = DK_RSVD;
        end
    end

    // Any requested qualifier bit that the mask does not enable
    assign bad_qual = |(desc[QW-1:0] & ~mask);

endmodule

// File: rtl/yq_peer_scan.sv
module yq_peer_scan #(
    parameter int NCTX = 4,
    parameter int CW   = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic [NCTX-1:0] bound,
    input  logic [NCTX-1:0] alloc,
    input  logic [NCTX-1:0] halted,
    input  logic [NCTX-1:0] active,
    input  logic [CW-1:0]   self_idx,
    output logic            peer_ok
);
    logic [NCTX-1:0] elig;

    for (genvar t = 0; t < NCTX; t++) begin : g_ctx
        assign elig[t] = bound[t] & alloc[t] & ~halted[t] & active[t]
                       & (self_idx != CW'(t));
    end

    assign peer_ok = |elig;

endmodule

// File: rtl/yield_qual_unit.sv
module yield_qual_unit
    import yq_pkg::*;
#(
    parameter int QW   = 31,
    parameter int NCTX = 4,
    localparam int DW  = QW + 1,
    localparam int CW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [DW-1:0]   req_desc,
    input  logic [4:0]      req_rs,
    input  logic [QW-1:0]   qual_in,
    input  logic [QW-1:0]   qual_mask,
    input  logic            sched_trap_en,
    input  logic            thread_debug,
    input  logic [NCTX-1:0] ctx_bound,
    input  logic [NCTX-1:0] ctx_alloc,
    input  logic [NCTX-1:0] ctx_halted,
    input  logic [NCTX-1:0] ctx_active,
    input  logic [CW-1:0]   self_ctx,
    output logic            blocked,
    output logic            resume,
    output logic            rsp_valid,
    output logic            rsp_dealloc,
    output logic            rsp_resched,
    output logic            rsp_exc,
    output logic [2:0]      rsp_cause,
    output logic            rsp_rsvd,
    output logic            wb_en,
    output logic [4:0]      wb_idx,
    output logic [DW-1:0]   wb_data
);
    yq_state_t      state_q, state_d;
    yq_kind_t       kind;
    logic           bad_qual;
    logic           peer_ok;
    logic [QW-1:0]  wait_desc_q;
    logic [4:0]     wait_rs_q;

    logic           accept, trap, match;
    logic           o_rsp, o_dealloc, o_resched, o_exc, o_rsvd, o_wb, o_resume;
    logic           go_wait;
    logic [2:0]     o_cause;
    logic [4:0]     o_idx;

    yq_decode #(.QW(QW)) u_decode (
        .desc     (req_desc),
        .mask     (qual_mask),
        .kind     (kind),
        .bad_qual (bad_qual)
    );

    yq_peer_scan #(.NCTX(NCTX), .CW(CW)) u_peers (
        .bound    (ctx_bound),
        .alloc    (ctx_alloc),
        .halted   (ctx_halted),
        .active   (ctx_active),
        .self_idx (self_ctx),
        .peer_ok  (peer_ok)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign trap   = sched_trap_en & thread_debug;
    assign match  = |(wait_desc_q & qual_mask & qual_in);

    // Outcome of the current cycle
    always_comb begin
        o_rsp     = 1'b0;
        o_dealloc = 1'b0;
        o_resched = 1'b0;
        o_exc     = 1'b0;
        o_cause   = CAUSE_UNDERFLOW;
        o_rsvd    = 1'b0;
        o_wb      = 1'b0;
        o_resume  = 1'b0;
        o_idx     = req_rs;
        go_wait   = 1'b0;
        if (accept) begin
            o_rsp = 1'b1;
            unique case (kind)
                DK_FREE: begin
                    if (!peer_ok) begin
                        o_exc   = 1'b1;
                        o_cause = CAUSE_UNDERFLOW;
                    end else if (trap) begin
                        o_exc   = 1'b1;
                        o_cause = CAUSE_SCHED;
                    end else begin
                        o_dealloc = 1'b1;
                        o_resched = 1'b1;
                        o_wb      = 1'b1;
                    end
                end
                DK_RESCHED: begin
                    if (trap) begin
                        o_exc   = 1'b1;
                        o_cause = CAUSE_SCHED;
                    end else begin
                        o_resched = 1'b1;
                        o_wb      = 1'b1;
                    end
                end
                DK_POLL: begin
                    o_wb = 1'b1;
                end
                DK_WAIT: begin
                    if (bad_qual) begin
                        o_exc   = 1'b1;
                        o_cause = CAUSE_BADQUAL;
                    end else if (trap) begin
                        o_exc   = 1'b1;
                        o_cause = CAUSE_SCHED;
                    end else begin
                        o_resched = 1'b1;
                        go_wait   = 1'b1;
                    end
                end
                DK_RSVD: begin
                    o_rsvd = 1'b1;
                end
            endcase
        end else if (state_q == ST_WAIT && match) begin
            o_resume = 1'b1;
            o_wb     = 1'b1;
            o_idx    = wait_rs_q;
        end
    end

    // Next state: complete / block / hold / release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = go_wait ? ST_WAIT : ST_IDLE;
            ST_WAIT: state_d = match ? ST_IDLE : ST_WAIT;
        endcase
    end

    // State register and wait context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            wait_desc_q <= '0;
            wait_rs_q   <= '0;
        end else begin
            state_q <= state_d;
            if (go_wait) begin
                wait_desc_q <= req_desc[QW-1:0];
                wait_rs_q   <= req_rs;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_dealloc <= 1'b0;
            rsp_resched <= 1'b0;
            rsp_exc     <= 1'b0;
            rsp_cause   <= '0;
            rsp_rsvd    <= 1'b0;
            resume      <= 1'b0;
            wb_en       <= 1'b0;
            wb_idx      <= '0;
            wb_data     <= '0;
        end else begin
            rsp_valid   <= o_rsp;
            rsp_dealloc <= o_dealloc;
            rsp_resched <= o_resched;
            rsp_exc     <= o_exc;
            rsp_cause   <= o_exc ? o_cause : 3'd0;
            rsp_rsvd    <= o_rsvd;
            resume      <= o_resume;
            wb_en       <= o_wb && (o_idx != 5'd0);
            wb_idx      <= o_idx;
            wb_data     <= {1'b0, qual_in & qual_mask};
        end
    end

    assign blocked = (state_q == ST_WAIT);

endmodule

// File: rtl/yield_qual_unit_chk.sv
module yield_qual_unit_chk #(
    parameter int QW = 31,
    localparam int DW = QW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [QW-1:0] qual_mask,
    input logic          blocked,
    input logic          resume,
    input logic          rsp_valid,
    input logic          rsp_dealloc,
    input logic          rsp_resched,
    input logic          rsp_exc,
    input logic          rsp_rsvd,
    input logic          wb_en,
    input logic [DW-1:0] wb_data
);
    // R2
    free_implies_resched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_dealloc |-> rsp_resched && rsp_valid);

    // R3
    exc_is_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_exc |-> !wb_en && !rsp_dealloc && !rsp_resched && !blocked);

    // R8
    block_with_resched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blocked) |-> rsp_resched && rsp_valid);

    // R9
    release_pulses_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blocked) |-> resume);

    // R9
    resume_not_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> !blocked && !rsp_valid);

    // R10
    wb_within_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> !wb_data[DW-1] && ((wb_data[QW-1:0] & ~$past(qual_mask)) == '0));

    // R11
    rsvd_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rsvd |-> !rsp_exc && !wb_en && !rsp_resched && !rsp_dealloc && !blocked);

    // R12
    no_reply_while_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> !rsp_valid && !rsp_exc && !rsp_rsvd && !rsp_dealloc);

endmodule

bind yield_qual_unit yield_qual_unit_chk #(.QW(QW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .qual_mask   (qual_mask),
    .blocked     (blocked),
    .resume      (resume),
    .rsp_valid   (rsp_valid),
    .rsp_dealloc (rsp_dealloc),
    .rsp_resched (rsp_resched),
    .rsp_exc     (rsp_exc),
    .rsp_rsvd    (rsp_rsvd),
    .wb_en       (wb_en),
    .wb_data     (wb_data)
);

// File: tb/yield_qual_unit_test.sv
module yield_qual_unit_test;
    localparam int QW = 31;
    localparam int DW = 32;
    localparam int NC = 4;

    logic clk = 0;
    always #2 clk = ~clk;

    logic          rst_n, req_valid, sched_trap_en, thread_debug;
    logic [DW-1:0] req_desc;
    logic [4:0]    req_rs;
    logic [QW-1:0] qual_in, qual_mask;
    logic [NC-1:0] ctx_bound, ctx_alloc, ctx_halted, ctx_active;
    logic [1:0]    self_ctx;
    logic          blocked, resume, rsp_valid, rsp_dealloc, rsp_resched, rsp_exc, rsp_rsvd, wb_en;
    logic [2:0]    rsp_cause;
    logic [4:0]    wb_idx;
    logic [DW-1:0] wb_data;

    int checks = 0, fails = 0;

    yield_qual_unit #(.QW(QW), .NCTX(NC)) uut (.*);

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // Issue one request, compute expected outcome, check; returns whether a wait began.
    task automatic run_req(input string tag, input logic [31:0] d, input logic [4:0] rs,
                           input logic [30:0] q, input logic [30:0] m, input logic ysi, input logic dt,
                           output logic e_blk);
        logic trap, peer, bad, e_dea, e_res, e_exc, e_rsv, e_wb;
        logic [2:0] e_cause;
        @(negedge clk);
        req_desc = d; req_rs = rs; qual_in = q; qual_mask = m;
        sched_trap_en = ysi; thread_debug = dt; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        trap = ysi & dt;
        peer = 0;
        for (int t = 0; t < NC; t++)
            if (ctx_bound[t] && ctx_alloc[t] && !ctx_halted[t] && ctx_active[t] && t != int'(self_ctx)) peer = 1;
        bad = |(d[30:0] & ~m);
        e_dea = 0; e_res = 0; e_exc = 0; e_rsv = 0; e_wb = 0; e_blk = 0; e_cause = 0;
        if (d == 0) begin
            if (!peer) e_exc = 1;
            else if (trap) begin e_exc = 1; e_cause = 4; end
            else begin e_dea = 1; e_res = 1; e_wb = 1; end
        end else if (d == 32'hFFFF_FFFF) begin
            if (trap) begin e_exc = 1; e_cause = 4; end
            else begin e_res = 1; e_wb = 1; end
        end else if (d == 32'hFFFF_FFFE) begin
            e_wb = 1;
        end else if (!d[31]) begin
            if (bad) begin e_exc = 1; e_cause = 2; end
            else if (trap) begin e_exc = 1; e_cause = 4; end
            else begin e_res = 1; e_blk = 1; end
        end else begin
            e_rsv = 1;
        end
        chk(tag, "rsp_valid", rsp_valid, 1);
        chk(tag, "dealloc", rsp_dealloc, e_dea);
        chk(tag, "resched", rsp_resched, e_res);
        chk(tag, "exc", rsp_exc, e_exc);
        if (e_exc) chk(tag, "cause", rsp_cause, e_cause);
        chk(tag, "rsvd", rsp_rsvd, e_rsv);
        chk(tag, "blocked", blocked, e_blk);
        chk(tag, "wb_en", wb_en, e_wb && rs != 0);
        if (e_wb && rs != 0) begin
            chk("R10", "wb_idx", wb_idx, rs);
            chk("R10", "wb_data", wb_data, {1'b0, q & m});
        end
    endtask

    // Drive a blocked thread through hold cycles, a stray request, then a match.
    task automatic wait_flow(input logic [31:0] d, input logic [4:0] rs, input logic [30:0] m);
        logic [30:0] nomatch, hit;
        nomatch = ~d[30:0];
        hit = d[30:0] & m & (~d[30:0] + 31'd1 | d[30:0]);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk) qual_in = nomatch;
            @(negedge clk);
            chk("R8", "hold blocked", blocked, 1);
            chk("R8", "hold resume", resume, 0);
        end
        @(negedge clk) begin req_desc = 32'hFFFF_FFFE; req_rs = 5'd3; req_valid = 1; end
        @(negedge clk) req_valid = 0;
        chk("R12", "stray rsp_valid", rsp_valid, 0);
        chk("R12", "stray wb_en", wb_en, 0);
        chk("R12", "still blocked", blocked, 1);
        qual_in = hit | nomatch;
        @(negedge clk);
        chk("R9", "blocked fell", blocked, 0);
        chk("R9", "resume", resume, 1);
        chk("R10", "wb_en resume", wb_en, rs != 0);
        if (rs != 0) chk("R10", "wb_data resume", wb_data, {1'b0, (hit | nomatch) & m});
        @(negedge clk);
        chk("R9", "resume pulse", resume, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic blk;
        logic [31:0] d;
        logic [30:0] q, m;
        void'($urandom(32'd7));
        rst_n = 0; req_valid = 0; req_desc = 0; req_rs = 0; qual_in = 0; qual_mask = 0;
        sched_trap_en = 0; thread_debug = 0; self_ctx = 0;
        ctx_bound = 0; ctx_alloc = 0; ctx_halted = 0; ctx_active = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk("R1", "blocked", blocked, 0);
        chk("R1", "resume", resume, 0);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "wb_en", wb_en, 0);

        // R2 / R3: one peer swept over all 16 status patterns, every self/peer pair
        for (int s = 0; s < NC; s++)
            for (int p = 0; p < NC; p++)
                for (int st = 0; st < 16; st++) begin
                    self_ctx = 2'(s);
                    ctx_bound = 0; ctx_alloc = 0; ctx_halted = 0; ctx_active = 0;
                    ctx_bound[s] = 1; ctx_alloc[s] = 1; ctx_active[s] = 1;
                    ctx_bound[p] = st[0]; ctx_alloc[p] = st[1];
                    ctx_halted[p] = st[2]; ctx_active[p] = st[3];
                    run_req((p != s && st == 4'b1011) ? "R2" : "R3", 32'd0, 5'(st + 1),
                            31'($urandom), 31'($urandom), 1'b0, 1'b0, blk);
                end

        // R4 / R5 / R7 / R10: -1, -2 and free with an eligible peer, all trap combos
        self_ctx = 0; ctx_bound = 4'b0011; ctx_alloc = 4'b0011; ctx_halted = 0; ctx_active = 4'b0011;
        for (int k = 0; k < 3; k++)
            for (int tr = 0; tr < 4; tr++)
                for (int r = 0; r < 3; r++) begin
                    d = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'hFFFF_FFFE : 32'd0;
                    run_req((tr == 3) ? ((k == 1) ? "R5" : "R7") : ((k == 0) ? "R4" : (k == 1) ? "R5" : "R2"),
                            d, (r == 0) ? 5'd0 : (r == 1) ? 5'd7 : 5'd31,
                            31'($urandom), 31'($urandom), tr[0], tr[1], blk);
                end

        // R6 / R7 / R8 / R9: each single qualifier bit, masked in or out
        for (int b = 0; b < QW; b++)
            for (int v = 0; v < 3; v++) begin
                d = 32'd1 << b;
                m = (v == 0) ? ~(31'd1 << b) : 31'h7FFF_FFFF;
                run_req((v == 0) ? "R6" : (v == 2) ? "R7" : "R8", d, 5'(b), 31'd0, m,
                        v == 2, v == 2, blk);
                if (blk) wait_flow(d, 5'(b), m);
            end

        // R6 / R8 / R9: multi-bit random descriptors
        for (int i = 0; i < 60; i++) begin
            m = 31'($urandom);
            d = {1'b0, 31'($urandom) & ((i % 2 == 0) ? m : 31'h7FFF_FFFF)};
            if (d == 0) d = 32'd1;
            run_req("R6", d, 5'(i), 31'd0, m, 1'b0, 1'b0, blk);
            if (blk) wait_flow(d, 5'(i), m);
        end

        // R9: mask revoked during wait keeps the thread blocked
        run_req("R8", 32'h0000_0010, 5'd9, 31'd0, 31'h0000_00F0, 1'b0, 1'b0, blk);
        @(negedge clk) begin qual_mask = 31'h0000_00E0; qual_in = 31'h0000_0010; end
        @(negedge clk);
        chk("R9", "revoked mask blocked", blocked, 1);
        chk("R9", "revoked mask resume", resume, 0);
        qual_mask = 31'h0000_00F0;
        @(negedge clk);
        chk("R9", "restored mask resume", resume, 1);
        chk("R10", "restored wb_data", wb_data, 32'h0000_0010);

        // R11: reserved negative descriptors, including the edges next to -1/-2
        run_req("R11", 32'h8000_0000, 5'd4, 31'd5, 31'd5, 1'b1, 1'b1, blk);
        run_req("R11", 32'hFFFF_FFFD, 5'd4, 31'd5, 31'd5, 1'b0, 1'b0, blk);
        for (int i = 0; i < 40; i++) begin
            d = $urandom | 32'h8000_0000;
            if (d == 32'hFFFF_FFFF || d == 32'hFFFF_FFFE) d = 32'hC000_0000;
            run_req("R11", d, 5'(i), 31'($urandom), 31'($urandom), i[0], i[1], blk);
        end

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule